// File: doc/BRIEF.md
# Line Switch State Controller

This block drives the six solid-state switch enables of a subscriber line interface: a pair of break switches that connect the line to the voice path, a pair of ringing switches that connect the ringing source, and a pair of test switches that connect a test bus. Two select pins and a test-enable pin are decoded into a named line state. An active-low latch input loads that state; while the latch input is high, the last loaded state is held.

A variant parameter picks the state set. The standard set has all-off, talk, ringing and test. The extended set has all-off, talk, ringing, test/monitor and ringing test. A mode pin picks the order of the ringing-to-talk handover: break-before-make (both pairs open for a dead time) or make-before-break (both pairs closed for the same dead time). The dead time is a parameter counted in clock cycles.

Supply undervoltage and battery loss arrive as asynchronous status inputs. They are synchronized, and while either is active all enables are forced open and the select pins have no effect. After the fault clears, the block stays in all-off until the latch input is driven low. The same locked all-off condition follows reset.

Top module: `line_sw_ctrl`

## Requirements
- R1: `state_o` codes are 0 all-off, 1 talk, 2 ringing, 3 test, 4 test/monitor, 5 ringing test. With `{sel_a_i,sel_b_i}` equal to 00, 01 and 10 (and `test_en_i` low) the loaded state is all-off, talk and ringing. All-off drives all enables to 0, talk drives only `brk_o`=11 and ringing drives only `ring_o`=11.
- R2: Select 11 loads test (only `tst_o`=11) when EXTENDED=0 and test/monitor (`brk_o`=11, `tst_o`=11) when EXTENDED=1. With EXTENDED=1, select 10 with `test_en_i` high loads ringing test (`ring_o`=11, `tst_o`=11). With EXTENDED=0, `test_en_i` has no effect.
- R3: While `latch_ni` is high and no lockout is active, `state_o` and the enables keep their values whatever the select pins do.
- R4: With EXTENDED=0, `state_o` never takes code 4 or 5.
- R5: A high level on `uv_i` or `batt_loss_i` drives `state_o` to 0 and all enables to 0 on the third rising clock edge after it is applied. While it stays high, the select and latch pins have no effect.
- R6: After both fault inputs return low, the block stays in all-off with `latch_ni` high. A low `latch_ni` sampled once the synchronized faults are clear releases the lock, and the selected state loads on the next edge.
- R7: Ringing to talk with `mbb_i` low: `state_o` changes on the loading edge, the enables still show ringing for one cycle, then both break and ringing enables are 0 for DEAD_CYCLES cycles, then talk is driven.
- R8: Ringing to talk with `mbb_i` high: the enables still show ringing for one cycle, then both break and ringing enables are 1 for DEAD_CYCLES cycles, then talk is driven.
- R9: After reset, `state_o` is 0, all enables are 0 and the block is locked, so selects latched with `latch_ni` high do not load.
- R10: The break enables never rise on the same edge on which the ringing enables fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_a_i | input | 1 | State select, upper bit |
| sel_b_i | input | 1 | State select, lower bit |
| latch_ni | input | 1 | Active-low load; high holds the state |
| test_en_i | input | 1 | Adds test closure to ringing (extended variant) |
| mbb_i | input | 1 | Handover order: 1 make-before-break, 0 break-before-make |
| uv_i | input | 1 | Supply undervoltage status, asynchronous |
| batt_loss_i | input | 1 | Battery loss status, asynchronous |
| state_o | output | 3 | Loaded line state code |
| brk_o | output | 2 | Break switch enables |
| ring_o | output | 2 | Ringing switch enables |
| tst_o | output | 2 | Test switch enables |

## Verification
The handover sequencer and the lockout can both act in the same cycle: a fault that arrives while the dead-time window is still counting must abandon the handover and open every switch, not finish the move to talk. The bench starts a make-before-break handover and raises `uv_i` inside the window. It requires all enables to be 0 three edges later and the locked all-off to persist until an explicit latch release. Random select, mode and test-enable patterns are then run against both variants side by side, and each settled state is compared with bench-computed codes and enables.

// File: rtl/line_sw_pkg.sv
package line_sw_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_TALK  = 3'd1,
    ST_RING  = 3'd2,
    ST_TEST  = 3'd3,
    ST_TMON  = 3'd4,
    ST_RTEST = 3'd5
  } line_st_e;

  typedef struct packed {
    logic brk;
    logic ring;
    logic tst;
  } sw_en_t;

  function automatic line_st_e decode_sel(input logic ext, input logic a,
                                          input logic b, input logic ten);
    line_st_e s;
    case ({a, b})
      2'b00:   s = ST_OFF;
      2'b01:   s = ST_TALK;
      2'b10:   s = (ext && ten) ? ST_RTEST : ST_RING;
      default: s = ext ? ST_TMON : ST_TEST;
    endcase
    return s;
  endfunction

  function automatic sw_en_t st_to_en(input line_st_e s);
    sw_en_t e;
    case (s)
      ST_TALK:  e = '{brk: 1'b1, ring: 1'b0, tst: 1'b0};
      ST_RING:  e = '{brk: 1'b0, ring: 1'b1, tst: 1'b0};
      ST_TEST:  e = '{brk: 1'b0, ring: 1'b0, tst: 1'b1};
      ST_TMON:  e = '{brk: 1'b1, ring: 1'b0, tst: 1'b1};
      ST_RTEST: e = '{brk: 1'b0, ring: 1'b1, tst: 1'b1};
      default:  e = '{brk: 1'b0, ring: 1'b0, tst: 1'b0};
    endcase
    return e;
  endfunction

endpackage

// File: rtl/line_sw_sync.sv
module line_sw_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/line_sw_fsm.sv
module line_sw_fsm
  import line_sw_pkg::*;
#(
  parameter bit EXTENDED = 1'b0
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     lockout_i,
  input  logic     latch_ni,
  input  logic     sel_a_i,
  input  logic     sel_b_i,
  input  logic     test_en_i,
  output line_st_e state_o,
  output logic     lock_o,
  output logic     force_off_o
);

  line_st_e state_q, state_d;
  logic     lock_q, lock_d;

  assign force_off_o = lockout_i | lock_q;

  // sticky lock: set by any fault, released only by latch low with faults clear
  assign lock_d = lockout_i | (lock_q & latch_ni);

  always_comb begin
    state_d = state_q;
    if (force_off_o)   state_d = ST_OFF;
    else if (!latch_ni) state_d = decode_sel(EXTENDED, sel_a_i, sel_b_i, test_en_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      lock_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      lock_q  <= lock_d;
    end
  end

  assign state_o = state_q;
  assign lock_o  = lock_q;

endmodule

// File: rtl/line_sw_seq.sv
module line_sw_seq
  import line_sw_pkg::*;
#(
  parameter int DEAD_CYCLES = 4
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   force_off_i,
  input  logic   mbb_i,
  input  sw_en_t tgt_i,
  output sw_en_t en_o
);

  localparam int CNT_W = $clog2(DEAD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DEAD_CYCLES - 1);

  sw_en_t           en_q, en_d;
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             to_talk;

  assign to_talk = tgt_i.brk & ~tgt_i.ring;

  always_comb begin
    en_d   = en_q;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (force_off_i) begin
      en_d   = '0;
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (!to_talk) begin
        en_d   = tgt_i;
        busy_d = 1'b0;
      end else if (cnt_q == '0) begin
        en_d   = tgt_i;
        busy_d = 1'b0;
      end else begin
        en_d.tst = tgt_i.tst;
        cnt_d    = cnt_q - CNT_W'(1);
      end
    end else if (en_q.ring && !en_q.brk && to_talk) begin
      // handover window: both open (bbm) or both closed (mbb)
      busy_d    = 1'b1;
      cnt_d     = CNT_LOAD;
      en_d.brk  = mbb_i;
      en_d.ring = mbb_i;
      en_d.tst  = tgt_i.tst;
    end else begin
      en_d = tgt_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      en_q   <= en_d;
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign en_o = en_q;

endmodule

// File: rtl/line_sw_ctrl.sv
module line_sw_ctrl
  import line_sw_pkg::*;
#(
  parameter bit EXTENDED    = 1'b0,
  parameter int DEAD_CYCLES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_a_i,
  input  logic       sel_b_i,
  input  logic       latch_ni,
  input  logic       test_en_i,
  input  logic       mbb_i,
  input  logic       uv_i,
  input  logic       batt_loss_i,
  output logic [2:0] state_o,
  output logic [1:0] brk_o,
  output logic [1:0] ring_o,
  output logic [1:0] tst_o
);

  logic [1:0] fault_s;
  logic       lockout;
  logic       lock_q;
  logic       force_off;
  line_st_e   state;
  sw_en_t     tgt_en;
  sw_en_t     sw_en;

  line_sw_sync #(
    .WIDTH (2),
    .STAGES(SYNC_STAGES)
  ) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({batt_loss_i, uv_i}),
    .sync_o (fault_s)
  );

  assign lockout = |fault_s;

  line_sw_fsm #(
    .EXTENDED(EXTENDED)
  ) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lockout_i  (lockout),
    .latch_ni   (latch_ni),
    .sel_a_i    (sel_a_i),
    .sel_b_i    (sel_b_i),
    .test_en_i  (test_en_i),
    .state_o    (state),
    .lock_o     (lock_q),
    .force_off_o(force_off)
  );

  assign tgt_en = st_to_en(state);

  line_sw_seq #(
    .DEAD_CYCLES(DEAD_CYCLES)
  ) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .force_off_i(force_off),
    .mbb_i      (mbb_i),
    .tgt_i      (tgt_en),
    .en_o       (sw_en)
  );

  assign state_o = state;
  assign brk_o   = {2{sw_en.brk}};
  assign ring_o  = {2{sw_en.ring}};
  assign tst_o   = {2{sw_en.tst}};

endmodule

// File: rtl/line_sw_chk.sv
module line_sw_chk #(
  parameter bit EXTENDED = 1'b0
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       latch_ni,
  input logic       force_off_i,
  input logic       lock_i,
  input logic [2:0] state_i,
  input logic [1:0] brk_i,
  input logic [1:0] ring_i,
  input logic [1:0] tst_i
);

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_ni && !force_off_i) |=> $stable(state_i));

  assert_variant_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (EXTENDED || state_i <= 3'd3) && state_i <= 3'd5);

  assert_force_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_off_i |=> (state_i == 3'd0 && brk_i == 2'b00 && ring_i == 2'b00 && tst_i == 2'b00));

  assert_lock_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> state_i == 3'd0);

  assert_no_swap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_i[0]) |-> !$fell(ring_i[0]));

endmodule

bind line_sw_ctrl line_sw_chk #(.EXTENDED(EXTENDED)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .latch_ni   (latch_ni),
  .force_off_i(force_off),
  .lock_i     (lock_q),
  .state_i    (state_o),
  .brk_i      (brk_o),
  .ring_i     (ring_o),
  .tst_i      (tst_o)
);

// File: tb/test_line_sw_ctrl.sv
`timescale 1ns/1ps
module test_line_sw_ctrl;

  localparam int DEAD = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_a = 1'b0, sel_b = 1'b0, latch_n = 1'b1, ten = 1'b0, mbb = 1'b0;
  logic uv = 1'b0, batt = 1'b0;
  logic [2:0] st_x, st_s;
  logic [1:0] brk_x, ring_x, tst_x, brk_s, ring_s, tst_s;
  int n_vec = 0, n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  line_sw_ctrl #(.EXTENDED(1'b1), .DEAD_CYCLES(DEAD)) i_line_sw_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sel_a_i(sel_a), .sel_b_i(sel_b), .latch_ni(latch_n),
    .test_en_i(ten), .mbb_i(mbb), .uv_i(uv), .batt_loss_i(batt),
    .state_o(st_x), .brk_o(brk_x), .ring_o(ring_x), .tst_o(tst_x));

  line_sw_ctrl #(.EXTENDED(1'b0), .DEAD_CYCLES(DEAD)) i_line_sw_ctrl_std (
    .clk_i(clk), .rst_ni(rst_n), .sel_a_i(sel_a), .sel_b_i(sel_b), .latch_ni(latch_n),
    .test_en_i(ten), .mbb_i(mbb), .uv_i(uv), .batt_loss_i(batt),
    .state_o(st_s), .brk_o(brk_s), .ring_o(ring_s), .tst_o(tst_s));

  function automatic int exp_state(bit ext, bit a, bit b, bit t);
    case ({a, b})
      2'b00:   return 0;
      2'b01:   return 1;
      2'b10:   return (ext && t) ? 5 : 2;
      default: return ext ? 4 : 3;
    endcase
  endfunction

  // {brk,ring,tst} per state code
  function automatic int exp_en(int s);
    case (s)
      1: return 3'b100;
      2: return 3'b010;
      3: return 3'b001;
      4: return 3'b101;
      5: return 3'b011;
      default: return 3'b000;
    endcase
  endfunction

  function automatic int en_x();
    return {brk_x[0] & brk_x[1], ring_x[0] & ring_x[1], tst_x[0] & tst_x[1]} |
           {brk_x != 2'b00 && brk_x != 2'b11, 2'b00} << 3;
  endfunction

  function automatic int en_s();
    return {brk_s[0] & brk_s[1], ring_s[0] & ring_s[1], tst_s[0] & tst_s[1]} |
           {brk_s != 2'b00 && brk_s != 2'b11, 2'b00} << 3;
  endfunction

  task automatic check(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load(bit a, bit b, bit t);
    sel_a = a; sel_b = b; ten = t; latch_n = 1'b0;
    step(1);
    latch_n = 1'b1;
    step(DEAD + 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    int s_exp;
    bit a0, b0, t0;
    void'($urandom(32'h5eed_71c3));
    step(3);
    check("R9 reset state", st_x, 0);
    check("R9 reset enables", en_x(), 0);
    rst_n = 1'b1;
    sel_a = 1'b0; sel_b = 1'b1;
    step(4);
    check("R9 locked after reset", st_x, 0);
    latch_n = 1'b0;
    step(1);
    check("R6 release edge still off", st_x, 0);
    step(1);
    check("R6 load after release", st_x, 1);
    latch_n = 1'b1;
    step(2);
    check("R1 talk enables", en_x(), 3'b100);

    // break-before-make handover
    load(1'b1, 1'b0, 1'b0);
    check("R1 ringing enables", en_x(), 3'b010);
    mbb = 1'b0; sel_a = 1'b0; sel_b = 1'b1; latch_n = 1'b0;
    step(1);
    latch_n = 1'b1;
    check("R7 state talk", st_x, 1);
    check("R7 ringing held one cycle", en_x(), 3'b010);
    for (int i = 0; i < DEAD; i++) begin
      step(1);
      check("R7 gap open", en_x(), 3'b000);
    end
    step(1);
    check("R7 talk after gap", en_x(), 3'b100);

    // make-before-break handover
    load(1'b1, 1'b0, 1'b0);
    mbb = 1'b1; sel_a = 1'b0; sel_b = 1'b1; latch_n = 1'b0;
    step(1);
    latch_n = 1'b1;
    check("R8 ringing held one cycle", en_x(), 3'b010);
    for (int i = 0; i < DEAD; i++) begin
      step(1);
      check("R8 overlap closed", en_x(), 3'b110);
    end
    step(1);
    check("R8 talk after overlap", en_x(), 3'b100);

    // fault inside a handover window
    load(1'b1, 1'b0, 1'b0);
    mbb = 1'b1; sel_a = 1'b0; sel_b = 1'b1; latch_n = 1'b0;
    step(1);
    latch_n = 1'b1;
    step(1);
    check("R8 overlap before fault", en_x(), 3'b110);
    uv = 1'b1;
    step(2);
    check("R5 not yet forced", en_x(), 3'b110);
    step(1);
    check("R5 forced off enables", en_x(), 3'b000);
    check("R5 forced off state", st_x, 0);
    sel_a = 1'b1; sel_b = 1'b0; latch_n = 1'b0;
    step(3);
    check("R5 inputs ignored", en_x(), 3'b000);
    latch_n = 1'b1; uv = 1'b0;
    step(6);
    check("R6 held off after recovery", st_x, 0);
    check("R6 enables off after recovery", en_x(), 3'b000);
    latch_n = 1'b0;
    step(1);
    check("R6 release edge", st_x, 0);
    step(1);
    check("R6 ringing loads", st_x, 2);
    latch_n = 1'b1;

    // battery loss, release latch while fault still synchronizing out
    step(2);
    batt = 1'b1;
    step(3);
    check("R5 battery loss off", st_x, 0);
    check("R5 battery loss std", st_s, 0);
    batt = 1'b0; latch_n = 1'b0; sel_a = 1'b0; sel_b = 1'b1;
    step(3);
    check("R6 off until faults clear", st_x, 0);
    step(1);
    check("R6 talk after battery return", st_x, 1);
    check("R6 talk std", st_s, 1);
    latch_n = 1'b1;
    step(DEAD + 3);

    // variant corners
    load(1'b1, 1'b1, 1'b0);
    check("R2 test/monitor ext", en_x(), 3'b101);
    check("R2 test std", en_s(), 3'b001);
    check("R4 std code", st_s, 3);
    load(1'b1, 1'b0, 1'b1);
    check("R2 ringing test ext", en_x(), 3'b011);
    check("R2 test_en ignored std", en_s(), 3'b010);
    check("R4 std ringing code", st_s, 2);

    // random loads and holds
    for (int i = 0; i < 200; i++) begin
      a0 = 1'($urandom); b0 = 1'($urandom); t0 = 1'($urandom);
      mbb = 1'($urandom);
      load(a0, b0, t0);
      s_exp = exp_state(1'b1, a0, b0, t0);
      check("R1/R2 ext state", st_x, s_exp);
      check("R1/R2 ext enables", en_x(), exp_en(s_exp));
      s_exp = exp_state(1'b0, a0, b0, t0);
      check("R4 std state", st_s, s_exp);
      check("R2 std enables", en_s(), exp_en(s_exp));
      sel_a = 1'($urandom); sel_b = 1'($urandom); ten = 1'($urandom);
      step(DEAD + 3);
      check("R3 hold ext", st_x, exp_state(1'b1, a0, b0, t0));
      check("R3 hold std enables", en_s(), exp_en(exp_state(1'b0, a0, b0, t0)));
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

endmodule